// File: doc/BRIEF.md
# Watchdog Timer with Postscaler

This block is a watchdog that runs from its own free-running clock, so it keeps counting while the main system clock is stopped. A base counter divides the watchdog clock by a parameterised terminal count; by default that period is chosen to be roughly 18 ms of watchdog clock. An optional power-of-two postscaler, selected by a 3-bit ratio field, lengthens the timeout by up to 1:128. When the postscaler is not assigned to the watchdog, the ratio is 1:1.

Software keeps the watchdog from firing by issuing a clear command. Entering sleep restarts the watchdog in the same way. Both strobes come from the system clock domain. Each passes through a two-flop synchroniser and a rising-edge detector. What a timeout does depends on the synchronised sleep status. In normal operation it produces a one-cycle device-reset pulse. While the device is asleep it produces a one-cycle wake-up pulse instead. An active-low time-out flag records that a timeout happened. A static enable bit removes the watchdog entirely.

All pins are plain control and status signals. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `wdt_core`

## Requirements
- R1: After power-up reset, `timeout_n` is 1, and `reset_pulse` and `wake_pulse` are 0.
- R2: With `ps_to_wdt` = 0, a timeout occurs every BASE_TC watchdog clock edges, whatever the value of `ps_ratio`.
- R3: With `ps_to_wdt` = 1, the timeout period is BASE_TC × 2^`ps_ratio` edges. The field value 0 selects 1:1, and 7 selects 1:128.
- R4: A rising edge on `clr_req` zeroes the base counter and the postscaler. The strobe is sampled high at watchdog edge e. The counters are zero after edge e+2. The next timeout is seen after edge e+2+period.
- R5: A rising edge on `sleep_req` restarts the counters with the same timing as R4.
- R6: A timeout while the synchronised `in_sleep` is 1 raises `wake_pulse` and not `reset_pulse`. Otherwise it raises `reset_pulse` and not `wake_pulse`.
- R7: `timeout_n` goes to 0 on the edge that raises a timeout pulse. It returns to 1 on the edge where a clear or sleep entry takes effect.
- R8: While `cfg_enable` = 0, no timeout occurs and both counters are held at zero. After enable is raised, the first timeout comes a full period later.
- R9: Holding `clr_req` high counts as a single clear. The watchdog still times out one period after that clear.
- R10: If `ps_ratio` is lowered below the postscaler's current count, the timeout fires at the next base-counter wrap and does not wrap the postscaler.
- R11: `reset_pulse` and `wake_pulse` are each one watchdog clock wide and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wdt_clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Active-low power-up reset |
| cfg_enable | input | 1 | Static enable; 0 disables the watchdog |
| clr_req | input | 1 | Clear command strobe (system clock domain) |
| sleep_req | input | 1 | Sleep-entry strobe (system clock domain) |
| in_sleep | input | 1 | Device sleep status (system clock domain) |
| ps_to_wdt | input | 1 | 1 assigns the postscaler to the watchdog |
| ps_ratio | input | 3 | Postscaler ratio exponent, 1:2^value |
| reset_pulse | output | 1 | One-cycle device-reset request |
| wake_pulse | output | 1 | One-cycle wake-up request |
| timeout_n | output | 1 | Active-low time-out status flag |

## Verification
The bench measures the timeout interval for every ratio class, including unassigned with a nonzero ratio. A design that ignored the assignment bit would time out 32 times too late. Clears and sleep entries are timed to the exact edge, and one clear strobe is held high. A missing synchroniser stage would shift the interval, and a level-sensitive clear would stop the watchdog for as long as the strobe is held. Lowering the ratio in the middle of a count exposes an equality compare, which would wrap the postscaler and delay the timeout by about 128 base periods. A long disabled window checks that the watchdog stays quiet and that its counters are cleared when it is enabled again.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

  typedef enum logic [1:0] {
    WDT_ACT_NONE  = 2'd0,
    WDT_ACT_RESET = 2'd1,
    WDT_ACT_WAKE  = 2'd2
  } wdt_act_e;

  // Choose what an expiry does, given the synchronised sleep state.
  function automatic wdt_act_e pick_action(input logic expire, input logic asleep);
    if (!expire)     return WDT_ACT_NONE;
    else if (asleep) return WDT_ACT_WAKE;
    else             return WDT_ACT_RESET;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser. With EDGE set, the output is a one-cycle
// pulse on each rising edge of the synchronised input.
module wdt_sync #(
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  generate
    if (EDGE) begin : g_edge
      logic last;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
      end
      assign q = chain[STAGES-1] & ~last;
    end else begin : g_level
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/wdt_base_counter.sv
`timescale 1ns/1ps
// Base divider: raises tick on the cycle it wraps from BASE_TC-1 to zero.
module wdt_base_counter #(
  parameter int BASE_TC = 576
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wipe,
  output logic tick
);
  localparam int CNT_W = (BASE_TC > 2) ? $clog2(BASE_TC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_TC - 1);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == LAST);
  assign tick    = en & ~wipe & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!en || wipe)    cnt <= '0;
    else if (at_last)        cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdt_postscaler.sv
`timescale 1ns/1ps
// Power-of-two postscaler counting base ticks. Expiry uses a
// greater-or-equal compare so a lowered ratio never wraps the count.
module wdt_postscaler #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               wipe,
  input  logic               assigned,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               tick,
  output logic               expire
);
  localparam int PS_W = (1 << RATIO_W) - 1;

  logic [PS_W-1:0] ps_cnt;
  logic [PS_W:0]   span;
  logic [PS_W-1:0] limit;
  logic            reached;

  always_comb begin
    span  = (PS_W+1)'(1) << (assigned ? ratio : '0);
    limit = PS_W'(span - 1'b1);
  end

  assign reached = (ps_cnt >= limit);
  assign expire  = tick & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ps_cnt <= '0;
    else if (!en || wipe)  ps_cnt <= '0;
    else if (tick) begin
      if (reached) ps_cnt <= '0;
      else         ps_cnt <= ps_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core #(
  parameter int BASE_TC     = 576,
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               wdt_clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               clr_req,
  input  logic               sleep_req,
  input  logic               in_sleep,
  input  logic               ps_to_wdt,
  input  logic [RATIO_W-1:0] ps_ratio,
  output logic               reset_pulse,
  output logic               wake_pulse,
  output logic               timeout_n
);
  import wdt_pkg::*;

  logic clr_evt, sleep_evt, asleep, wipe;
  logic tick, expire;
  wdt_act_e act_q;
  logic flag_q;

  wdt_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_clr_sync (
    .clk(wdt_clk), .rst_n(rst_n), .d(clr_req), .q(clr_evt));

  wdt_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sleep_req_sync (
    .clk(wdt_clk), .rst_n(rst_n), .d(sleep_req), .q(sleep_evt));

  wdt_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_sleep_lvl_sync (
    .clk(wdt_clk), .rst_n(rst_n), .d(in_sleep), .q(asleep));

  assign wipe = clr_evt | sleep_evt;

  wdt_base_counter #(.BASE_TC(BASE_TC)) u_base (
    .clk(wdt_clk), .rst_n(rst_n), .en(cfg_enable), .wipe(wipe), .tick(tick));

  wdt_postscaler #(.RATIO_W(RATIO_W)) u_post (
    .clk(wdt_clk), .rst_n(rst_n), .en(cfg_enable), .wipe(wipe),
    .assigned(ps_to_wdt), .ratio(ps_ratio), .tick(tick), .expire(expire));

  always_ff @(posedge wdt_clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= WDT_ACT_NONE;
      flag_q <= 1'b1;
    end else begin
      act_q <= pick_action(expire, asleep);
      if (wipe)        flag_q <= 1'b1;
      else if (expire) flag_q <= 1'b0;
    end
  end

  assign reset_pulse = (act_q == WDT_ACT_RESET);
  assign wake_pulse  = (act_q == WDT_ACT_WAKE);
  assign timeout_n   = flag_q;
endmodule

// File: rtl/wdt_core_chk.sv
`timescale 1ns/1ps
module wdt_core_chk (
  input logic wdt_clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic reset_pulse,
  input logic wake_pulse,
  input logic timeout_n
);
  p_excl_pulse_r11: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    $onehot0({reset_pulse, wake_pulse}))
    else $error("R11 reset and wake pulses overlap");

  p_reset_width_r11: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    reset_pulse |=> !reset_pulse)
    else $error("R11 reset pulse wider than one cycle");

  p_wake_width_r11: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse)
    else $error("R11 wake pulse wider than one cycle");

  p_flag_low_r7: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    (reset_pulse || wake_pulse) |-> !timeout_n)
    else $error("R7 status flag high during a timeout pulse");

  p_disabled_quiet_r8: assert property (@(posedge wdt_clk) disable iff (!rst_n)
    !cfg_enable |=> !(reset_pulse || wake_pulse))
    else $error("R8 timeout while disabled");
endmodule

bind wdt_core wdt_core_chk u_chk (.*);

// File: tb/tb_wdt_core.sv
`timescale 1ns/1ps
module tb_wdt_core;
  localparam int TC = 20;
  localparam int NV = 6;
  localparam int SYNC_LAT = 3;

  // vector table: assign, ratio, asleep, expect wake
  localparam int V_ASG [NV] = '{0, 1, 1, 1, 1, 0};
  localparam int V_RAT [NV] = '{5, 0, 3, 7, 2, 7};
  localparam int V_SLP [NV] = '{0, 0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, clr_req = 1'b0, sleep_req = 1'b0, in_sleep = 1'b0;
  logic ps_to_wdt = 1'b0;
  logic [2:0] ps_ratio = 3'd0;
  logic reset_pulse, wake_pulse, timeout_n;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int start_c;
  int got_n;
  bit got_rst, got_wake;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_core #(.BASE_TC(TC)) dut (
    .wdt_clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .clr_req(clr_req),
    .sleep_req(sleep_req), .in_sleep(in_sleep), .ps_to_wdt(ps_to_wdt),
    .ps_ratio(ps_ratio), .reset_pulse(reset_pulse), .wake_pulse(wake_pulse),
    .timeout_n(timeout_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // wait for a timeout pulse at negedges; report interval since start_c
  task automatic wait_pulse(input int limit);
    got_rst = 1'b0; got_wake = 1'b0; got_n = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (reset_pulse || wake_pulse) begin
        got_rst = reset_pulse; got_wake = wake_pulse; got_n = cyc - start_c;
        return;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(timeout_n === 1'b1, "R1 flag in reset", timeout_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(timeout_n === 1'b1 && !reset_pulse && !wake_pulse, "R1 after reset",
          {timeout_n, reset_pulse, wake_pulse}, 3'b100);

    // table walk: R2 R3 R6
    for (int v = 0; v < NV; v++) begin
      int period;
      period = TC * ((V_ASG[v] != 0) ? (1 << V_RAT[v]) : 1);
      cfg_enable = 1'b0;
      ps_to_wdt = (V_ASG[v] != 0);
      ps_ratio = 3'(V_RAT[v]);
      in_sleep = (V_SLP[v] != 0);
      repeat (5) @(negedge clk);
      cfg_enable = 1'b1;
      start_c = cyc;
      wait_pulse(period + 50);
      check(got_n == period, (V_ASG[v] != 0) ? "R3 period" : "R2 period", got_n, period);
      check(got_wake == (V_SLP[v] != 0) && got_rst == (V_SLP[v] == 0), "R6 action",
            {got_rst, got_wake}, (V_SLP[v] != 0) ? 1 : 2);
      check(timeout_n === 1'b0, "R7 flag low at timeout", timeout_n, 0);
      @(negedge clk);
      check(!reset_pulse && !wake_pulse, "R11 one-cycle pulse", {reset_pulse, wake_pulse}, 0);
    end
    in_sleep = 1'b0;

    // R4 R9 R7: clear held high right after a timeout
    cfg_enable = 1'b0; ps_to_wdt = 1'b0;
    repeat (5) @(negedge clk);
    cfg_enable = 1'b1;
    start_c = cyc;
    wait_pulse(TC + 10);
    check(got_n == TC, "R2 base period", got_n, TC);
    start_c = cyc;
    clr_req = 1'b1;
    repeat (SYNC_LAT) @(negedge clk);
    check(timeout_n === 1'b1, "R7 flag set by clear", timeout_n, 1);
    wait_pulse(TC + 20);
    check(got_n == TC + SYNC_LAT, "R4 clear restart timing", got_n, TC + SYNC_LAT);
    start_c = cyc;
    wait_pulse(TC + 20);
    check(got_n == TC, "R9 held clear acts once", got_n, TC);
    clr_req = 1'b0;

    // R5 sleep entry, then wake while asleep
    @(negedge clk);
    start_c = cyc - 1;
    sleep_req = 1'b1;
    in_sleep = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    wait_pulse(TC + 20);
    check(got_n == TC + SYNC_LAT + 1, "R5 sleep restart timing", got_n, TC + SYNC_LAT + 1);
    check(got_wake && !got_rst, "R6 wake while asleep", {got_rst, got_wake}, 1);
    in_sleep = 1'b0;

    // R10 ratio lowered below current postscaler count
    cfg_enable = 1'b0; ps_to_wdt = 1'b1; ps_ratio = 3'd7;
    repeat (5) @(negedge clk);
    cfg_enable = 1'b1;
    start_c = cyc;
    while (cyc < start_c + 5 * TC + 2) @(negedge clk);
    ps_ratio = 3'd1;
    wait_pulse(200 * TC);
    check(got_n == 6 * TC, "R10 lowered ratio", got_n, 6 * TC);

    // R8 disabled window then full period after enable
    cfg_enable = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (reset_pulse || wake_pulse) seen++;
      end
      check(seen == 0, "R8 quiet while disabled", seen, 0);
    end
    ps_ratio = 3'd2;
    cfg_enable = 1'b1;
    start_c = cyc;
    wait_pulse(8 * TC);
    check(got_n == 4 * TC, "R8 full period after enable", got_n, 4 * TC);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule